// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status flags

This block is the arithmetic and logic core of a small eight-bit datapath. Each cycle it combines an accumulator operand with a second operand, and in some operations with a carry input, under a four-bit operation select. The eight-bit result appears combinationally on the result port. A separate strobe tells the surrounding logic whether the result should be written back to the accumulator.

Five status flags sit in a register inside the block: sign, zero, nibble carry, even parity and carry. The register loads on the clock edge at which the flag write enable is high. Each operation class decides which flags it changes and which it keeps. The carry input is supplied from outside, normally from the stored carry flag, and it feeds the add-with-carry, subtract-with-borrow and through-carry rotates. The block has no register file, no decoder and no bus logic.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+cy_in, both modulo 256. The carry flag is set when the unsigned sum exceeds 255.
- R2: Code 2 (subtract) gives A−B and code 3 (subtract with borrow) gives A−B−cy_in, both modulo 256. The carry flag acts as a borrow and is set when A is smaller than B (plus cy_in for code 3).
- R3: Code 4 (increment) gives A+1 and code 5 (decrement) gives A−1. Both keep the stored carry flag and update the other four flags.
- R4: Code 6 gives A AND B, code 7 gives A OR B and code 8 gives A XOR B. All three clear both the carry flag and the nibble-carry flag.
- R5: After any add, subtract, compare, increment, decrement or logic operation, the flags are set from the result as follows. Sign (flags_o bit 4) equals result bit 7. Zero (bit 3) is set exactly when the result is 0. Parity (bit 1) is set exactly when the result has an even number of ones.
- R6: The nibble-carry flag (flags_o bit 2) is the carry out of bit 3 of the internal addition. For add-type operations this is A[3:0]+B[3:0](+cy_in). For subtract-type operations it is A[3:0]+~B[3:0]+1 (minus cy_in for code 3). Increment sets it when A[3:0]=F and decrement sets it when A[3:0]≠0.
- R7: Code 9 (compare) drives acc_we_o low and updates every flag exactly as code 2 would. All other codes drive acc_we_o high.
- R8: Code 10 gives the one's complement of A and leaves all five flags unchanged.
- R9: Code 11 rotates left with bit 7 wrapping into bit 0. Code 12 rotates right with bit 0 wrapping into bit 7. Code 13 rotates left through carry, with cy_in entering bit 0. Code 14 rotates right through carry, with cy_in entering bit 7. In every rotate the carry flag takes the bit shifted out, and the other four flags (flags_o bits 4:1) are kept.
- R10: On a clock edge with flag_we low, flags_o does not change.
- R11: While rst_n is low, flags_o is 0.
- R12: Code 15 passes B to the result and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| op_sel | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Accumulator operand A |
| opb_in | input | 8 | Second operand B |
| cy_in | input | 1 | Carry/borrow input for codes 1, 3, 13, 14 |
| flag_we | input | 1 | Flag register write enable |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | High when the result is to be written to the accumulator |
| flags_o | output | 5 | Stored flags {sign, zero, nibble carry, parity, carry} |

## Verification
The flag register is the block's only state, and a wrong value in it appears on flags_o one clock edge after the faulty write. A fault confined to the result logic shows on result_o in the same cycle. A flag that is wrongly updated or wrongly held matters most in the classes that must preserve some flags: rotates, increment/decrement and complement. There a bad write stays visible across the following preserving operations until a full-update operation overwrites it. This is why the stimulus chains preserving operations after arbitrary flag states and compares the flags after every edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam int unsigned OPW = 4;
  localparam int unsigned FW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CMP  = 4'd9,
    OP_CPL  = 4'd10,
    OP_ROLW = 4'd11,
    OP_RORW = 4'd12,
    OP_ROLC = 4'd13,
    OP_RORC = 4'd14,
    OP_MOVB = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    CL_FULL  = 3'd0,
    CL_STEP  = 3'd1,
    CL_LOGIC = 3'd2,
    CL_ROT   = 3'd3,
    CL_KEEP  = 3'd4
  } flag_cls_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic flag_cls_e op_class(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: op_class = CL_FULL;
      OP_INC, OP_DEC:                         op_class = CL_STEP;
      OP_AND, OP_OR, OP_XOR:                  op_class = CL_LOGIC;
      OP_ROLW, OP_RORW, OP_ROLC, OP_RORC:     op_class = CL_ROT;
      default:                                op_class = CL_KEEP;
    endcase
  endfunction

  function automatic logic is_subtract(input alu_op_e op);
    is_subtract = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

  function automatic logic even_ones(input logic [DW-1:0] v);
    even_ones = ~(^v);
  endfunction

  function automatic logic all_zero(input logic [DW-1:0] v);
    all_zero = (v == '0);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cy_out,
  output logic           nib_cy
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] addend;
  logic         carry0;
  logic [W:0]   chain;
  logic [W-1:0] bits;

  always_comb begin
    addend = b;
    carry0 = 1'b0;
    case (op)
      OP_ADD:         begin addend = b;       carry0 = 1'b0; end
      OP_ADC:         begin addend = b;       carry0 = cin;  end
      OP_SUB, OP_CMP: begin addend = ~b;      carry0 = 1'b1; end
      OP_SBB:         begin addend = ~b;      carry0 = ~cin; end
      OP_INC:         begin addend = '0;      carry0 = 1'b1; end
      OP_DEC:         begin addend = '1;      carry0 = 1'b0; end
      default:        begin addend = b;       carry0 = 1'b0; end
    endcase
  end

  assign chain[0] = carry0;

  for (genvar gi = 0; gi < W; gi++) begin : g_ripple
    assign bits[gi]     = a[gi] ^ addend[gi] ^ chain[gi];
    assign chain[gi+1]  = (a[gi] & addend[gi]) | (chain[gi] & (a[gi] ^ addend[gi]));
  end

  assign sum    = bits;
  assign cy_out = is_subtract(op) ? ~chain[W] : chain[W];
  assign nib_cy = chain[HALF];

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CPL:  res = ~a;
      default: res = b;
    endcase
  end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cy_out
);

  logic left;
  logic fill;

  always_comb begin
    left = (op == OP_ROLW) || (op == OP_ROLC);
    case (op)
      OP_ROLW: fill = a[W-1];
      OP_RORW: fill = a[0];
      default: fill = cin;
    endcase
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_shift
    if (gi == 0) begin : g_lsb
      assign res[gi] = left ? fill : a[gi+1];
    end else if (gi == W - 1) begin : g_msb
      assign res[gi] = left ? a[gi-1] : fill;
    end else begin : g_mid
      assign res[gi] = left ? a[gi-1] : a[gi+1];
    end
  end

  assign cy_out = left ? a[W-1] : a[0];

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  flag_cls_e    cls,
  input  logic [W-1:0] res,
  input  logic         cy_new,
  input  logic         ac_new,
  output flags_t       flags_q
);

  flags_t nxt;

  always_comb begin
    nxt = flags_q;
    case (cls)
      CL_FULL: begin
        nxt.s  = res[W-1];
        nxt.z  = all_zero(res);
        nxt.ac = ac_new;
        nxt.p  = even_ones(res);
        nxt.cy = cy_new;
      end
      CL_STEP: begin
        nxt.s  = res[W-1];
        nxt.z  = all_zero(res);
        nxt.ac = ac_new;
        nxt.p  = even_ones(res);
      end
      CL_LOGIC: begin
        nxt.s  = res[W-1];
        nxt.z  = all_zero(res);
        nxt.ac = 1'b0;
        nxt.p  = even_ones(res);
        nxt.cy = 1'b0;
      end
      CL_ROT: begin
        nxt.cy = cy_new;
      end
      default: nxt = flags_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (we) begin
      flags_q <= nxt;
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_sel,
  input  logic [W-1:0]   acc_in,
  input  logic [W-1:0]   opb_in,
  input  logic           cy_in,
  input  logic           flag_we,
  output logic [W-1:0]   result_o,
  output logic           acc_we_o,
  output logic [FW-1:0]  flags_o
);

  alu_op_e      op;
  flag_cls_e    cls;
  logic [W-1:0] arith_res;
  logic         arith_cy;
  logic         arith_ac;
  logic [W-1:0] logic_res;
  logic [W-1:0] rot_res;
  logic         rot_cy;
  logic         cy_sel;
  flags_t       flags_q;
  logic         flags_upd;

  assign op  = alu_op_e'(op_sel);
  assign cls = op_class(op);

  alu8_arith #(.W(W)) u_arith (
    .op     (op),
    .a      (acc_in),
    .b      (opb_in),
    .cin    (cy_in),
    .sum    (arith_res),
    .cy_out (arith_cy),
    .nib_cy (arith_ac)
  );

  alu8_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (acc_in),
    .b   (opb_in),
    .res (logic_res)
  );

  alu8_rotate #(.W(W)) u_rot (
    .op     (op),
    .a      (acc_in),
    .cin    (cy_in),
    .res    (rot_res),
    .cy_out (rot_cy)
  );

  always_comb begin
    case (cls)
      CL_FULL, CL_STEP: result_o = arith_res;
      CL_ROT:           result_o = rot_res;
      default:          result_o = logic_res;
    endcase
  end

  assign cy_sel    = (cls == CL_ROT) ? rot_cy : arith_cy;
  assign flags_upd = flag_we && (cls != CL_KEEP);

  alu8_flags #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (flag_we),
    .cls     (cls),
    .res     (result_o),
    .cy_new  (cy_sel),
    .ac_new  (arith_ac),
    .flags_q (flags_q)
  );

  assign acc_we_o = (op != OP_CMP);
  assign flags_o  = flags_q;

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] op_sel,
  input logic           flag_we,
  input logic [W-1:0]   acc_in,
  input logic [W-1:0]   result_o,
  input logic           acc_we_o,
  input logic [FW-1:0]  flags_o,
  input logic           flags_upd,
  input flag_cls_e      cls
);

  logic res_cls;
  assign res_cls = flags_upd && (cls != CL_ROT);

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_cls |=> flags_o[3] == ($past(result_o) == '0));

  assert_sign_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_cls |=> (flags_o[4] == $past(result_o[W-1])) &&
                (flags_o[1] == ($countones($past(result_o)) % 2 == 0)));

  assert_step_keeps_cy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == 4'd4 || op_sel == 4'd5)) |=> flags_o[0] == $past(flags_o[0]));

  assert_logic_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == 4'd6 || op_sel == 4'd7 || op_sel == 4'd8)) |=>
      (flags_o[0] == 1'b0) && (flags_o[2] == 1'b0));

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd9) |-> !acc_we_o);

  assert_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd10) |-> (result_o == ~acc_in));

  assert_cpl_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd10) |=> $stable(flags_o));

  assert_rot_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel >= 4'd11 && op_sel <= 4'd14) |=> flags_o[4:1] == $past(flags_o[4:1]));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_o));

  assert_movb_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd15) |=> $stable(flags_o));

  always_comb begin
    if (!rst_n) begin
      assert_reset_R11: assert (flags_o == '0);
    end
  end

endmodule

bind alu8_core alu8_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .flag_we   (flag_we),
  .acc_in    (acc_in),
  .result_o  (result_o),
  .acc_we_o  (acc_we_o),
  .flags_o   (flags_o),
  .flags_upd (flags_upd),
  .cls       (cls)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] acc_in = '0;
  logic [7:0] opb_in = '0;
  logic       cy_in = 1'b0;
  logic       flag_we = 1'b0;
  logic [7:0] result_o;
  logic       acc_we_o;
  logic [4:0] flags_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [4:0] exp_flags = '0;

  always #2.5 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in), .opb_in(opb_in),
    .cy_in(cy_in), .flag_we(flag_we), .result_o(result_o), .acc_we_o(acc_we_o),
    .flags_o(flags_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  // returns {acc_we, flags[4:0], result[7:0]}
  function automatic logic [13:0] model(input int op, input int a, input int b,
                                        input int c, input logic [4:0] f);
    int res; int cy; int ac; int kind; int s;
    logic [4:0] nf;
    cy = f[0]; ac = f[2]; kind = 0; res = 0;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? c : 0);
        res = s % 256; cy = (s > 255); ac = ((a % 16) + (b % 16) + ((op == 1) ? c : 0)) > 15;
        kind = 1;
      end
      2, 3, 9: begin
        s = a - b - ((op == 3) ? c : 0);
        res = (s + 512) % 256; cy = (s < 0);
        ac = ((a % 16) + (15 - (b % 16)) + ((op == 3) ? 1 - c : 1)) > 15;
        kind = 1;
      end
      4: begin res = (a + 1) % 256; ac = ((a % 16) == 15); kind = 1; end
      5: begin res = (a + 255) % 256; ac = ((a % 16) != 0); kind = 1; end
      6: begin res = a & b; cy = 0; ac = 0; kind = 1; end
      7: begin res = a | b; cy = 0; ac = 0; kind = 1; end
      8: begin res = a ^ b; cy = 0; ac = 0; kind = 1; end
      10: res = 255 - a;
      11: begin res = ((a * 2) % 256) + (a / 128); cy = a / 128; kind = 2; end
      12: begin res = (a / 2) + 128 * (a % 2); cy = a % 2; kind = 2; end
      13: begin res = ((a * 2) % 256) + c; cy = a / 128; kind = 2; end
      14: begin res = (a / 2) + 128 * c; cy = a % 2; kind = 2; end
      default: res = b;
    endcase
    nf = f;
    if (kind == 1) begin
      nf[4] = (res >= 128);
      nf[3] = (res == 0);
      nf[2] = ac[0];
      nf[1] = (ones(res) % 2 == 0);
      nf[0] = cy[0];
    end else if (kind == 2) begin
      nf[0] = cy[0];
    end
    return {(op != 9) ? 1'b1 : 1'b0, nf, res[7:0]};
  endfunction

  function automatic string rtag(input int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R3";
      6, 7, 8: return "R4";
      9: return "R7";
      10: return "R8";
      15: return "R12";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input int op, input int a, input int b, input int c, input bit we,
                      input string ftag);
    logic [13:0] m;
    @(negedge clk);
    op_sel = op[3:0]; acc_in = a[7:0]; opb_in = b[7:0]; cy_in = c[0]; flag_we = we;
    m = model(op, a, b, c, exp_flags);
    #1;
    check({rtag(op), " result"}, result_o, m[7:0]);
    check("R7 acc_we", acc_we_o, m[13]);
    @(posedge clk);
    #1;
    if (we) exp_flags = m[12:8];
    check({ftag, " flags"}, flags_o, exp_flags);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_A1B2);
    repeat (2) @(posedge clk);
    #1;
    check("R11 reset flags", flags_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step(0, 8'h80, 8'h80, 0, 1, "R1 R5 zero+carry");
    step(1, 8'h0F, 8'h00, 1, 1, "R6 nibble carry adc");
    step(2, 8'h05, 8'h06, 0, 1, "R2 borrow");
    step(3, 8'h10, 8'h0F, 1, 1, "R2 R6 sbb");
    step(9, 8'h42, 8'h42, 0, 1, "R7 compare equal");
    step(9, 8'h01, 8'h02, 0, 1, "R7 compare borrow");
    step(4, 8'hFF, 8'h00, 0, 1, "R3 inc keeps carry");
    step(5, 8'h00, 8'h00, 0, 1, "R3 R6 dec");
    step(0, 8'hFF, 8'h01, 0, 1, "R1 set carry");
    step(13, 8'h01, 8'h00, 0, 1, "R9 rotl through carry");
    step(14, 8'h01, 8'h00, 1, 1, "R9 rotr through carry");
    step(11, 8'h81, 8'h00, 0, 1, "R9 rotl wrap");
    step(12, 8'h02, 8'h00, 1, 1, "R9 rotr wrap");
    step(6, 8'hF0, 8'h0F, 0, 1, "R4 R5 and zero");
    step(10, 8'h5A, 8'h00, 0, 1, "R8 cpl keeps flags");
    step(0, 8'h7F, 8'h7F, 0, 0, "R10 hold");
    step(15, 8'h00, 8'hA5, 0, 1, "R12 move b");

    for (int i = 0; i < 400; i++) begin
      int op; int a; int b; int c; bit we;
      op = $urandom_range(0, 15);
      a = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      c = $urandom_range(0, 1);
      we = ($urandom_range(0, 7) != 0);
      step(op, a, b, c, we, we ? {rtag(op), " R5 R6 random"} : "R10 random hold");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule